// File: doc/BRIEF.md
# Serial Management Tunnel to a 32-bit Register Bus

This block is a slave on a two-wire serial management bus (clock-22 style frames: preamble, start, opcode, 5-bit device address, 5-bit register number, turnaround, 16 data bits). It lets a host that can only move 16-bit values reach a 32-bit, word-aligned internal register space. A page register holds the upper word-address bits. The remaining bits are carried inside the device address and the register number of each frame. The lowest register-number bit picks which half of the 32-bit word is moved.

Frames are decoded in the local clock domain from a synchronized copy of the management clock. A 32-bit write is sent as the upper half first and then the lower half. The upper half is only staged. The lower half issues one internal write carrying both halves. A 32-bit read starts with the lower half, which performs one internal read and captures the upper half. The read of the upper half that follows returns the captured value, so the two halves always come from the same internal access.

Top module: `mrb_bridge`

## Requirements
- R1: After reset, mdio_oe, bus_we and bus_re are 0, bus_addr is 0 and the page register is 0.
- R2: A frame is accepted only after at least 32 consecutive ones followed by start bits 0 then 1. Opcode 01 (MSB first) is a write and 10 is a read. Opcodes 00 and 11, and frames with a shorter preamble, cause no bus access and no drive.
- R3: A write frame to device address 0x1F, register 0x10 loads data bits [8:0] into the page register. Any other frame at device 0x1F (another register, or a read) changes nothing and is not answered.
- R4: The internal byte address is {page[8:0], devaddr[2:0], regnum[4:1], 2'b00} (18 bits). Only device addresses 0x10 to 0x17 reach the bus.
- R5: A write with regnum bit 0 = 1 (upper half) stages its 16 data bits and makes no bus access.
- R6: A write with regnum bit 0 = 0 (lower half) makes exactly one bus write, with bus_wdata = {last staged upper half, frame data}. The staged half persists across lower writes.
- R7: A read with regnum bit 0 = 0 makes exactly one bus read and returns bus_rdata[15:0] in the frame.
- R8: A read with regnum bit 0 = 1 makes no bus access and returns bus_rdata[31:16] as captured by the most recent lower-half read, even if the register has changed since.
- R9: In a read frame the slave leaves the line released during the first turnaround bit, drives 0 in the second, then drives the 16 data bits MSB first, one per management clock. It updates the line after a falling management-clock edge.
- R10: Frames to device addresses outside 0x10 to 0x17 (other than the page write of R3) cause no bus access, and mdio_oe stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| mdc | input | 1 | Management clock from the host |
| mdio_i | input | 1 | Management data line as seen at the pin |
| mdio_o | output | 1 | Value driven onto the data line when enabled |
| mdio_oe | output | 1 | Output enable for the data line |
| bus_addr | output | 18 | Internal byte address, word aligned |
| bus_wdata | output | 32 | Internal write data |
| bus_we | output | 1 | One-cycle internal write strobe |
| bus_re | output | 1 | One-cycle internal read strobe |
| bus_rdata | input | 32 | Internal read data, valid in the cycle bus_re is high |

## Verification
The hardest case to reach from the ports is a torn 32-bit read, where a register changes between the lower-half and upper-half frames. The bench's register model derives its contents from the address and a bench-owned modifier. Changing the modifier between the two read frames makes a bridge that re-reads, or that does not latch, return a value different from the one captured at the lower-half read. Malformed traffic is a second concern: short preambles, illegal opcodes, foreign device addresses and non-page registers at 0x1F are mixed between legal frames. The scoreboard must stay empty and the line must stay released for those frames.

// File: rtl/mrb_pkg.sv
`timescale 1ns/1ps
package mrb_pkg;

  localparam int MD_DATA_W = 16;
  localparam int MD_FIELD_W = 5;

  localparam logic [MD_FIELD_W-1:0] PAGE_DEV = 5'h1F;
  localparam logic [MD_FIELD_W-1:0] PAGE_REG = 5'h10;

  localparam logic [1:0] OPC_WRITE = 2'b01;
  localparam logic [1:0] OPC_READ  = 2'b10;

  typedef enum logic [1:0] {
    FR_HUNT,
    FR_START,
    FR_BODY
  } fr_state_e;

  // device addresses 0x10..0x17 tunnel into the register space
  function automatic logic is_tunnel_dev(input logic [MD_FIELD_W-1:0] dev);
    return dev[4:3] == 2'b10;
  endfunction

  function automatic logic is_page_sel(input logic [MD_FIELD_W-1:0] dev,
                                       input logic [MD_FIELD_W-1:0] rno);
    return (dev == PAGE_DEV) && (rno == PAGE_REG);
  endfunction

  // word offset inside one page: three device bits above four register bits
  function automatic logic [6:0] page_offset(input logic [2:0] dev_lo,
                                             input logic [3:0] reg_hi);
    return {dev_lo, reg_hi};
  endfunction

endpackage

// File: rtl/mrb_mdc_sampler.sv
`timescale 1ns/1ps
module mrb_mdc_sampler #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mdc,
  input  logic mdio_i,
  output logic mdc_rise,
  output logic mdc_fall,
  output logic mdio_s
);

  logic [STAGES-1:0] mdc_sync;
  logic [STAGES-1:0] dat_sync;
  logic              mdc_prev;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          mdc_sync <= '0;
          dat_sync <= '1;
        end else begin
          mdc_sync <= mdc;
          dat_sync <= mdio_i;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          mdc_sync <= '0;
          dat_sync <= '1;
        end else begin
          mdc_sync <= {mdc_sync[STAGES-2:0], mdc};
          dat_sync <= {dat_sync[STAGES-2:0], mdio_i};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) mdc_prev <= 1'b0;
    else        mdc_prev <= mdc_sync[STAGES-1];
  end

  assign mdc_rise = mdc_sync[STAGES-1] & ~mdc_prev;
  assign mdc_fall = ~mdc_sync[STAGES-1] & mdc_prev;
  assign mdio_s   = dat_sync[STAGES-1];

endmodule

// File: rtl/mrb_frame_rx.sv
`timescale 1ns/1ps
module mrb_frame_rx
  import mrb_pkg::*;
#(
  parameter int PRE_MIN = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  smp,
  input  logic                  bit_in,
  output logic                  ev_rd,
  output logic                  ev_wr,
  output logic [MD_FIELD_W-1:0] ev_dev,
  output logic [MD_FIELD_W-1:0] ev_reg,
  output logic [MD_DATA_W-1:0]  ev_data,
  output logic                  rd_act,
  output logic [4:0]            last_idx
);

  localparam int PRE_CW = $clog2(PRE_MIN + 1);
  localparam logic [4:0] IDX_HDR = 5'd11;
  localparam logic [4:0] IDX_END = 5'd29;

  fr_state_e             st;
  logic [PRE_CW-1:0]     pre_cnt;
  logic [4:0]            bit_cnt;
  logic [MD_DATA_W-2:0]  shreg;
  logic [1:0]            opc_q;
  logic [11:0]           hdr_now;
  logic [MD_DATA_W-1:0]  dat_now;

  assign hdr_now = {shreg[10:0], bit_in};
  assign dat_now = {shreg, bit_in};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= FR_HUNT;
      pre_cnt  <= '0;
      bit_cnt  <= '0;
      shreg    <= '0;
      opc_q    <= 2'b00;
      ev_rd    <= 1'b0;
      ev_wr    <= 1'b0;
      ev_dev   <= '0;
      ev_reg   <= '0;
      ev_data  <= '0;
      rd_act   <= 1'b0;
      last_idx <= '0;
    end else begin
      ev_rd <= 1'b0;
      ev_wr <= 1'b0;
      if (smp) begin
        unique case (st)
          FR_HUNT: begin
            if (bit_in) begin
              if (pre_cnt != PRE_CW'(PRE_MIN)) pre_cnt <= pre_cnt + 1'b1;
            end else begin
              if (pre_cnt == PRE_CW'(PRE_MIN)) st <= FR_START;
              pre_cnt <= '0;
            end
          end
          FR_START: begin
            if (bit_in) begin
              st      <= FR_BODY;
              bit_cnt <= '0;
            end else begin
              st <= FR_HUNT;
            end
          end
          FR_BODY: begin
            shreg    <= dat_now[MD_DATA_W-2:0];
            bit_cnt  <= bit_cnt + 1'b1;
            last_idx <= bit_cnt;
            if (bit_cnt == IDX_HDR) begin
              opc_q  <= hdr_now[11:10];
              ev_dev <= hdr_now[9:5];
              ev_reg <= hdr_now[4:0];
              if (hdr_now[11:10] == OPC_READ && is_tunnel_dev(hdr_now[9:5])) begin
                ev_rd  <= 1'b1;
                rd_act <= 1'b1;
              end
            end
            if (bit_cnt == IDX_END) begin
              ev_data <= dat_now;
              st      <= FR_HUNT;
              pre_cnt <= '0;
              rd_act  <= 1'b0;
              if (opc_q == OPC_WRITE && (is_tunnel_dev(ev_dev) || ev_dev == PAGE_DEV))
                ev_wr <= 1'b1;
            end
          end
          default: st <= FR_HUNT;
        endcase
      end
    end
  end

  // R2: events never overlap, a frame carries one direction only
  a_r2_one_event: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_rd && ev_wr));

  // R2: a write event only closes a frame body
  a_r2_wr_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wr |-> (st == FR_HUNT) && (last_idx == IDX_END));

endmodule

// File: rtl/mrb_access_ctrl.sv
`timescale 1ns/1ps
module mrb_access_ctrl
  import mrb_pkg::*;
#(
  parameter int PAGE_W = 9,
  parameter int DATA_W = 32,
  parameter int ADDR_W = PAGE_W + 9
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ev_rd,
  input  logic                  ev_wr,
  input  logic [MD_FIELD_W-1:0] ev_dev,
  input  logic [MD_FIELD_W-1:0] ev_reg,
  input  logic [MD_DATA_W-1:0]  ev_data,
  input  logic [DATA_W-1:0]     bus_rdata,
  output logic [ADDR_W-1:0]     bus_addr,
  output logic [DATA_W-1:0]     bus_wdata,
  output logic                  bus_we,
  output logic                  bus_re,
  output logic [MD_DATA_W-1:0]  rsp_q
);

  localparam int HALF_W = DATA_W / 2;

  logic [PAGE_W-1:0] page_q;
  logic [HALF_W-1:0] stage_q;
  logic [HALF_W-1:0] hi_lat_q;
  logic [ADDR_W-1:0] addr_now;
  logic              page_load;
  logic              tunnel;
  logic              upper_half;

  assign addr_now   = {page_q, page_offset(ev_dev[2:0], ev_reg[4:1]), 2'b00};
  assign page_load  = ev_wr && is_page_sel(ev_dev, ev_reg);
  assign tunnel     = is_tunnel_dev(ev_dev);
  assign upper_half = ev_reg[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page_q    <= '0;
      stage_q   <= '0;
      hi_lat_q  <= '0;
      rsp_q     <= '0;
      bus_addr  <= '0;
      bus_wdata <= '0;
      bus_we    <= 1'b0;
      bus_re    <= 1'b0;
    end else begin
      bus_we <= 1'b0;
      bus_re <= 1'b0;
      if (page_load) page_q <= ev_data[PAGE_W-1:0];
      if (ev_wr && tunnel) begin
        if (upper_half) begin
          stage_q <= ev_data;
        end else begin
          bus_we    <= 1'b1;
          bus_addr  <= addr_now;
          bus_wdata <= {stage_q, ev_data};
        end
      end
      if (ev_rd) begin
        if (upper_half) begin
          rsp_q <= hi_lat_q;
        end else begin
          bus_re   <= 1'b1;
          bus_addr <= addr_now;
        end
      end
      if (bus_re) begin
        rsp_q    <= bus_rdata[HALF_W-1:0];
        hi_lat_q <= bus_rdata[DATA_W-1:HALF_W];
      end
    end
  end

  // R3: the page moves only on a write event
  a_r3_page_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_wr |=> $stable(page_q));

  // R4: read events reach the bus side only for tunnel devices
  a_r4_rd_tunnel: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rd |-> ev_dev[4:3] == 2'b10);

  // R6: never a write and a read together
  a_r6_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_re));

  // R6: a write strobe lasts one cycle
  a_r6_we_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we |=> !bus_we);

  // R8: an upper-half read leaves the bus idle
  a_r8_upper_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rd && ev_reg[0]) |=> !bus_re);

endmodule

// File: rtl/mrb_mdio_tx.sv
`timescale 1ns/1ps
module mrb_mdio_tx
  import mrb_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fall,
  input  logic                 rd_act,
  input  logic [4:0]           last_idx,
  input  logic [MD_DATA_W-1:0] rsp,
  output logic                 mdio_o,
  output logic                 mdio_oe
);

  localparam logic [4:0] IDX_TA1   = 5'd12;
  localparam logic [4:0] IDX_LASTD = 5'd28;

  logic [3:0] sel;
  assign sel = 4'(IDX_LASTD - last_idx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mdio_o  <= 1'b0;
      mdio_oe <= 1'b0;
    end else if (fall) begin
      if (rd_act && last_idx == IDX_TA1) begin
        mdio_oe <= 1'b1;
        mdio_o  <= 1'b0;
      end else if (rd_act && last_idx > IDX_TA1 && last_idx <= IDX_LASTD) begin
        mdio_oe <= 1'b1;
        mdio_o  <= rsp[sel];
      end else begin
        mdio_oe <= 1'b0;
        mdio_o  <= 1'b0;
      end
    end
  end

  // R9: the first driven bit is the turnaround zero
  a_r9_ta_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdio_oe) |-> !mdio_o);

  // R10: drive begins only inside an accepted read frame
  a_r10_drive_in_read: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdio_oe) |-> rd_act);

endmodule

// File: rtl/mrb_bridge.sv
`timescale 1ns/1ps
module mrb_bridge
  import mrb_pkg::*;
#(
  parameter int PAGE_W  = 9,
  parameter int DATA_W  = 32,
  parameter int PRE_MIN = 32,
  parameter int SYNC_N  = 2,
  parameter int ADDR_W  = PAGE_W + 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mdc,
  input  logic              mdio_i,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              bus_we,
  output logic              bus_re,
  input  logic [DATA_W-1:0] bus_rdata
);

  logic                  mdc_rise;
  logic                  mdc_fall;
  logic                  mdio_s;
  logic                  ev_rd;
  logic                  ev_wr;
  logic [MD_FIELD_W-1:0] ev_dev;
  logic [MD_FIELD_W-1:0] ev_reg;
  logic [MD_DATA_W-1:0]  ev_data;
  logic                  rd_act;
  logic [4:0]            last_idx;
  logic [MD_DATA_W-1:0]  rsp;

  mrb_mdc_sampler #(.STAGES(SYNC_N)) u_sampler (
    .clk      (clk),
    .rst_n    (rst_n),
    .mdc      (mdc),
    .mdio_i   (mdio_i),
    .mdc_rise (mdc_rise),
    .mdc_fall (mdc_fall),
    .mdio_s   (mdio_s)
  );

  mrb_frame_rx #(.PRE_MIN(PRE_MIN)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .smp      (mdc_rise),
    .bit_in   (mdio_s),
    .ev_rd    (ev_rd),
    .ev_wr    (ev_wr),
    .ev_dev   (ev_dev),
    .ev_reg   (ev_reg),
    .ev_data  (ev_data),
    .rd_act   (rd_act),
    .last_idx (last_idx)
  );

  mrb_access_ctrl #(.PAGE_W(PAGE_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev_rd     (ev_rd),
    .ev_wr     (ev_wr),
    .ev_dev    (ev_dev),
    .ev_reg    (ev_reg),
    .ev_data   (ev_data),
    .bus_rdata (bus_rdata),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .bus_re    (bus_re),
    .rsp_q     (rsp)
  );

  mrb_mdio_tx u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .fall     (mdc_fall),
    .rd_act   (rd_act),
    .last_idx (last_idx),
    .rsp      (rsp),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe)
  );

  // R1: nothing is strobed or driven in the cycle after reset is released
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !bus_we && !bus_re && !mdio_oe);

endmodule

// File: tb/mrb_bridge_bench.sv
`timescale 1ns/1ps
module mrb_bridge_bench;

  localparam int HALF = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mdc = 1'b0;
  logic        m_en = 1'b0;
  logic        m_val = 1'b1;
  logic        line;
  logic        mdio_o, mdio_oe;
  logic [17:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        bus_we, bus_re;
  logic [15:0] salt = 16'h0000;

  int    errors = 0;
  int    checks = 0;
  bit    done = 1'b0;
  bit    oe_seen = 1'b0;
  string cur_req = "R1";
  int    cur_page = 0;

  typedef struct {
    bit          wr;
    logic [17:0] a;
    logic [31:0] d;
  } exp_t;
  exp_t sbq[$];

  always #4 clk = ~clk;

  assign line = mdio_oe ? mdio_o : (m_en ? m_val : 1'b1);

  // test register file: contents follow the address and a bench-owned modifier
  function automatic logic [31:0] regval(input logic [17:0] a, input logic [15:0] s);
    logic [15:0] w;
    w = a[17:2];
    return {w ^ 16'h3C5A ^ s, w ^ 16'hF00F ^ ~s};
  endfunction

  assign bus_rdata = regval(bus_addr, salt);

  function automatic logic [17:0] xaddr(input int pg, input int dev, input int rg);
    return 18'((pg * 512) + ((dev % 8) * 64) + ((rg / 2) * 4));
  endfunction

  mrb_bridge u_mrb_bridge (
    .clk       (clk),
    .rst_n     (rst_n),
    .mdc       (mdc),
    .mdio_i    (line),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .bus_re    (bus_re),
    .bus_rdata (bus_rdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp,
                     input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // monitor: every bus strobe must match the next expected item
  always @(negedge clk) begin
    if (mdio_oe) oe_seen = 1'b1;
    if (rst_n && (bus_we || bus_re)) begin
      exp_t e;
      if (sbq.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL %s unexpected bus access: actual we=%0b re=%0b addr=%h expected none",
                 cur_req, bus_we, bus_re, bus_addr);
      end else begin
        e = sbq.pop_front();
        chk(cur_req, {30'd0, bus_we, bus_re}, e.wr ? 32'd2 : 32'd1, "access kind");
        chk(cur_req, {14'd0, bus_addr}, {14'd0, e.a}, "bus address");
        if (e.wr) chk(cur_req, bus_wdata, e.d, "write data");
      end
    end
  end

  task automatic send_bit(input logic b, input logic en, output logic seen, output logic oe_s);
    @(negedge clk);
    mdc   = 1'b0;
    m_en  = en;
    m_val = b;
    repeat (HALF) @(negedge clk);
    seen = line;
    oe_s = mdio_oe;
    mdc  = 1'b1;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic mframe(input int npre, input logic [1:0] op, input logic [4:0] dev,
                        input logic [4:0] rg, input logic [15:0] wd,
                        output logic [15:0] rd, output logic ta1_line,
                        output logic ta1_oe, output logic ta2_line);
    logic s, o;
    bit   is_rd;
    is_rd   = (op == 2'b10);
    oe_seen = 1'b0;
    rd      = '0;
    for (int i = 0; i < npre; i++) send_bit(1'b1, 1'b1, s, o);
    send_bit(1'b0, 1'b1, s, o);
    send_bit(1'b1, 1'b1, s, o);
    for (int i = 1; i >= 0; i--) send_bit(op[i], 1'b1, s, o);
    for (int i = 4; i >= 0; i--) send_bit(dev[i], 1'b1, s, o);
    for (int i = 4; i >= 0; i--) send_bit(rg[i], 1'b1, s, o);
    send_bit(1'b1, !is_rd, ta1_line, ta1_oe);
    send_bit(1'b0, !is_rd, ta2_line, o);
    for (int i = 15; i >= 0; i--) begin
      send_bit(wd[i], !is_rd, s, o);
      rd[i] = s;
    end
    @(negedge clk);
    mdc  = 1'b0;
    m_en = 1'b0;
    repeat (2 * HALF) @(negedge clk);
    chk(cur_req, sbq.size(), 0, "expected bus access still pending");
  endtask

  task automatic wr16(input logic [4:0] dev, input logic [4:0] rg, input logic [15:0] d);
    logic [15:0] r;
    logic a, b, c;
    mframe(32, 2'b01, dev, rg, d, r, a, b, c);
  endtask

  task automatic rd16(input logic [4:0] dev, input logic [4:0] rg, output logic [15:0] r);
    logic a, b, c;
    mframe(32, 2'b10, dev, rg, 16'h0000, r, a, b, c);
  endtask

  task automatic set_page(input int pg);
    cur_req = "R3";
    wr16(5'h1F, 5'h10, 16'(pg));
    cur_page = pg;
  endtask

  task automatic push_wr(input logic [17:0] a, input logic [31:0] d);
    exp_t e;
    e.wr = 1'b1; e.a = a; e.d = d;
    sbq.push_back(e);
  endtask

  task automatic push_rd(input logic [17:0] a);
    exp_t e;
    e.wr = 1'b0; e.a = a; e.d = '0;
    sbq.push_back(e);
  endtask

  // lower-half read then upper-half read, returning the assembled word
  task automatic rd32(input logic [4:0] dev, input logic [4:0] rg_even, output logic [31:0] v);
    logic [15:0] lo, hi;
    push_rd(xaddr(cur_page, dev, rg_even));
    rd16(dev, rg_even, lo);
    rd16(dev, rg_even | 5'h01, hi);
    v = {hi, lo};
  endtask

  initial begin : main
    logic [15:0] r;
    logic [31:0] v, expv;
    logic        t1, t1oe, t2;
    logic [17:0] a;

    repeat (5) @(negedge clk);
    chk("R1", {31'd0, mdio_oe}, 0, "oe in reset");
    chk("R1", {31'd0, bus_we}, 0, "bus_we in reset");
    chk("R1", {31'd0, bus_re}, 0, "bus_re in reset");
    chk("R1", {14'd0, bus_addr}, 0, "bus_addr in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: page is 0 after reset, seen in the first access address
    cur_req = "R1";
    push_rd(xaddr(0, 5'h11, 5'h02));
    rd16(5'h11, 5'h02, r);

    // R3 / R4 / R6: page load, then an ordered 32-bit write
    set_page(9'h155);
    cur_req = "R6";
    wr16(5'h13, 5'h0B, 16'hDEAD);
    push_wr(xaddr(cur_page, 5'h13, 5'h0A), 32'hDEADBEEF);
    wr16(5'h13, 5'h0A, 16'hBEEF);

    // R5: an upper-half write alone stays quiet
    cur_req = "R5";
    wr16(5'h12, 5'h03, 16'h1234);
    chk("R5", {31'd0, oe_seen}, 0, "line driven on write");
    cur_req = "R6";
    push_wr(xaddr(cur_page, 5'h12, 5'h02), 32'h1234ABCD);
    wr16(5'h12, 5'h02, 16'hABCD);
    push_wr(xaddr(cur_page, 5'h12, 5'h04), 32'h12340001);
    wr16(5'h12, 5'h04, 16'h0001);

    // R7 / R8 / R9: coherent read with a register change in between
    cur_req = "R7";
    a = xaddr(cur_page, 5'h10, 5'h00);
    push_rd(a);
    mframe(32, 2'b10, 5'h10, 5'h00, 16'h0000, r, t1, t1oe, t2);
    expv = regval(a, salt);
    chk("R7", {16'd0, r}, {16'd0, expv[15:0]}, "lower half read");
    chk("R9", {31'd0, t1oe}, 0, "oe during first turnaround bit");
    chk("R9", {31'd0, t1}, 1, "line during first turnaround bit");
    chk("R9", {31'd0, t2}, 0, "line during second turnaround bit");
    salt = 16'h0F0F;
    cur_req = "R8";
    rd16(5'h10, 5'h01, r);
    chk("R8", {16'd0, r}, {16'd0, expv[31:16]}, "upper half from lower-read capture");

    // R4: address boundaries of the tunnel range and the page
    set_page(0);
    cur_req = "R4";
    rd32(5'h17, 5'h1E, v);
    chk("R4", v, regval(18'h001FC, salt), "top of page 0 word");
    set_page(9'h1FF);
    cur_req = "R4";
    rd32(5'h10, 5'h00, v);
    chk("R4", v, regval(18'h3FE00, salt), "first word of last page");

    // R10: foreign device addresses
    cur_req = "R10";
    wr16(5'h05, 5'h00, 16'h5555);
    chk("R10", {31'd0, oe_seen}, 0, "line driven for foreign write");
    rd16(5'h18, 5'h00, r);
    chk("R10", {31'd0, oe_seen}, 0, "line driven for foreign read");
    chk("R10", {16'd0, r}, 32'h0000FFFF, "foreign read line released");
    rd16(5'h0F, 5'h02, r);
    chk("R10", {31'd0, oe_seen}, 0, "line driven for device 0x0F");

    // R2: illegal opcodes and short preamble
    cur_req = "R2";
    mframe(32, 2'b00, 5'h10, 5'h00, 16'h1111, r, t1, t1oe, t2);
    mframe(32, 2'b11, 5'h10, 5'h00, 16'h2222, r, t1, t1oe, t2);
    chk("R2", {31'd0, oe_seen}, 0, "line driven for opcode 11");
    mframe(16, 2'b01, 5'h10, 5'h00, 16'h3333, r, t1, t1oe, t2);
    mframe(20, 2'b10, 5'h10, 5'h00, 16'h0000, r, t1, t1oe, t2);
    chk("R2", {31'd0, oe_seen}, 0, "line driven after short preamble");
    push_wr(xaddr(cur_page, 5'h14, 5'h06), 32'h12344444);
    wr16(5'h14, 5'h06, 16'h4444);

    // R3: other frames at the page device leave the page alone
    cur_req = "R3";
    wr16(5'h1F, 5'h11, 16'h00AA);
    rd16(5'h1F, 5'h10, r);
    chk("R3", {31'd0, oe_seen}, 0, "line driven for page read");
    push_wr(xaddr(9'h1FF, 5'h15, 5'h08), 32'h12340077);
    wr16(5'h15, 5'h08, 16'h0077);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL %s watchdog: actual=timeout expected=completion", cur_req);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule